// File: doc/BRIEF.md
# Warp Instruction Issue Gate

This block sits between the decoded instruction stream of one warp and the execution pipelines, and decides in every cycle whether the pending instruction may go. Each instruction arrives with four control fields chosen by the compiler: a pacing count, a hint that the warp may be switched out, an optional dependency counter to claim, and a mask of dependency counters that must be empty before it goes.

Two checks gate issue, and both must pass in the same cycle. The first is a countdown that is loaded from the pacing count whenever an instruction issues. The second looks at six dependency counters. A variable-latency producer raises one of them when it issues, and that producer's completion report lowers it again. Several producers may share one counter, so a single wait covers the whole group. A completion that has no matching producer is dropped and recorded in a sticky error flag.

Top module: `warp_issue_gate`

## Requirements
- R1: After reset all dependency counters are zero, the pacing countdown is expired and the error flag is low, so the first valid instruction issues in the first cycle it is presented.
- R2: An instruction that issues with pacing count S (1 to 15) lets the next instruction issue no earlier than S cycles later; S = 1 allows back-to-back issue and a pacing count of 0 behaves as 1.
- R3: While `instr_valid` is high and any counter whose bit is set in `instr_wait_mask` (bit k selects counter k) is non-zero, the instruction does not issue and `blocked` is high; `issue_fire` and `blocked` are never high together.
- R4: On issue, a claim field value k from 0 to 5 raises counter k by one; the values 6 and 7 claim no counter.
- R5: A counter claimed by N producers stays non-zero until N completions for it have arrived.
- R6: A completion with index k (0 to 5) lowers counter k by one, and an instruction waiting only on that counter issues in the cycle after the completion that brings it to zero.
- R7: A claim and a completion for the same counter in the same cycle leave that counter unchanged.
- R8: A completion for a counter that is already zero, or with an index of 6 or 7, changes no counter and sets `cmpl_err` from the next cycle on; only reset clears it.
- R9: `yield_hint` equals the yield flag of the instruction in the cycle it issues and is low in every other cycle.
- R10: The pacing countdown and the counter check act independently: a running countdown blocks an instruction whose counters are clear, and a busy counter blocks an instruction whose countdown has expired.
- R11: A counter is 3 bits wide and saturates at 7: a claim on a counter that holds 7 leaves it at 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A pending instruction is presented |
| instr_ready | output | 1 | Countdown expired and every waited counter is zero |
| instr_stall | input | 4 | Pacing count of the pending instruction |
| instr_yield | input | 1 | Yield flag of the pending instruction |
| instr_set_sb | input | 3 | Counter to claim (0 to 5), 6 or 7 for none |
| instr_wait_mask | input | 6 | Counters that must be zero, one bit each |
| cmpl_valid | input | 1 | A producer completion is reported |
| cmpl_sb | input | 3 | Counter index of the reported completion |
| issue_fire | output | 1 | The pending instruction issues this cycle |
| blocked | output | 1 | An instruction is pending but may not issue |
| yield_hint | output | 1 | Yield flag of the instruction issuing now |
| cmpl_err | output | 1 | Sticky flag for an unmatched or invalid completion |

## Verification
The bound checker watches, in every cycle, the pacing gap after a multi-cycle issue, the blocking caused by a busy waited counter, the step of each counter on a claim or a completion, the hold when both arrive together, saturation at 7, the raising and stickiness of the error flag, and the yield hint being tied to an issue. Only the bench scenarios show the timing of whole sequences: the exact cycle on which a waiting instruction is released after the last of several shared completions, the treatment of pacing count 0, claim values 6 and 7 having no effect on any later wait, and the error flag being cleared by reset.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;

    // Operation applied to a single dependency counter in one cycle.
    typedef enum logic [1:0] {
        SB_HOLD = 2'b00,
        SB_DEC  = 2'b01,
        SB_INC  = 2'b10,
        SB_BOTH = 2'b11
    } sb_op_e;

    function automatic sb_op_e sb_op_of(input logic inc, input logic dec);
        return sb_op_e'({inc, dec});
    endfunction

endpackage

// File: rtl/issue_pace_timer.sv
module issue_pace_timer #(
    parameter int STALL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [STALL_W-1:0] stall,
    output logic               expired
);
    typedef struct packed {
        logic [STALL_W-1:0] remain;
    } pace_state_t;

    pace_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // A pacing count of zero behaves like one: back-to-back issue.
            if (stall == '0) begin
                st_d.remain = '0;
            end else begin
                st_d.remain = stall - 1'b1;
            end
        end else if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.remain == '0);

endmodule

// File: rtl/sb_counter.sv
module sb_counter
    import issue_gate_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             underflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    sb_op_e     op;

    always_comb begin
        st_d      = st_q;
        underflow = 1'b0;
        op        = sb_op_of(inc, dec);
        unique case (op)
            SB_INC: begin
                if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SB_DEC: begin
                if (st_q.cnt == '0) begin
                    underflow = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            SB_BOTH: st_d = st_q;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/sb_bank.sv
module sb_bank #(
    parameter int NUM_SB = 6,
    parameter int CNT_W  = 3,
    parameter int SEL_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         claim_fire,
    input  logic [SEL_W-1:0]             claim_sel,
    input  logic                         cmpl_valid,
    input  logic [SEL_W-1:0]             cmpl_sel,
    output logic [NUM_SB-1:0][CNT_W-1:0] counts,
    output logic [NUM_SB-1:0]            busy,
    output logic                         bad_cmpl
);
    localparam logic [SEL_W-1:0] FIRST_INVALID = SEL_W'(NUM_SB);

    logic [NUM_SB-1:0] inc_vec;
    logic [NUM_SB-1:0] dec_vec;
    logic [NUM_SB-1:0] uflow_vec;
    logic              sel_out_of_range;

    for (genvar k = 0; k < NUM_SB; k++) begin : g_cnt
        assign inc_vec[k] = claim_fire && (claim_sel == SEL_W'(k));
        assign dec_vec[k] = cmpl_valid && (cmpl_sel == SEL_W'(k));

        sb_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (inc_vec[k]),
            .dec       (dec_vec[k]),
            .count     (counts[k]),
            .underflow (uflow_vec[k])
        );

        assign busy[k] = (counts[k] != '0);
    end

    assign sel_out_of_range = cmpl_valid && (cmpl_sel >= FIRST_INVALID);
    assign bad_cmpl         = sel_out_of_range || (|uflow_vec);

endmodule

// File: rtl/warp_issue_gate.sv
module warp_issue_gate #(
    parameter int NUM_SB  = 6,
    parameter int CNT_W   = 3,
    parameter int STALL_W = 4,
    localparam int SEL_W  = $clog2(NUM_SB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [STALL_W-1:0] instr_stall,
    input  logic              instr_yield,
    input  logic [SEL_W-1:0]  instr_set_sb,
    input  logic [NUM_SB-1:0] instr_wait_mask,
    input  logic              cmpl_valid,
    input  logic [SEL_W-1:0]  cmpl_sb,
    output logic              issue_fire,
    output logic              blocked,
    output logic              yield_hint,
    output logic              cmpl_err
);
    typedef struct packed {
        logic err;
    } gate_state_t;

    gate_state_t st_d, st_q;

    logic                         pace_done;
    logic [NUM_SB-1:0]            sb_busy;
    logic [NUM_SB-1:0][CNT_W-1:0] sb_count;
    logic                         bad_cmpl;
    logic                         deps_clear;

    issue_pace_timer #(
        .STALL_W (STALL_W)
    ) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (issue_fire),
        .stall   (instr_stall),
        .expired (pace_done)
    );

    sb_bank #(
        .NUM_SB (NUM_SB),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .claim_fire (issue_fire),
        .claim_sel  (instr_set_sb),
        .cmpl_valid (cmpl_valid),
        .cmpl_sel   (cmpl_sb),
        .counts     (sb_count),
        .busy       (sb_busy),
        .bad_cmpl   (bad_cmpl)
    );

    always_comb begin
        deps_clear  = ((instr_wait_mask & sb_busy) == '0);
        instr_ready = pace_done && deps_clear;
        issue_fire  = instr_valid && instr_ready;
        blocked     = instr_valid && !instr_ready;
        yield_hint  = issue_fire && instr_yield;

        st_d = st_q;
        if (bad_cmpl) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmpl_err = st_q.err;

endmodule

// File: rtl/warp_issue_gate_chk.sv
module warp_issue_gate_chk #(
    parameter int NUM_SB  = 6,
    parameter int CNT_W   = 3,
    parameter int STALL_W = 4,
    parameter int SEL_W   = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         instr_valid,
    input logic [STALL_W-1:0]           instr_stall,
    input logic                         instr_yield,
    input logic [SEL_W-1:0]             instr_set_sb,
    input logic [NUM_SB-1:0]            instr_wait_mask,
    input logic                         cmpl_valid,
    input logic [SEL_W-1:0]             cmpl_sb,
    input logic                         issue_fire,
    input logic                         blocked,
    input logic                         yield_hint,
    input logic                         cmpl_err,
    input logic [NUM_SB-1:0][CNT_W-1:0] sb_count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [NUM_SB-1:0] nonzero;
    for (genvar k = 0; k < NUM_SB; k++) begin : g_nz
        assign nonzero[k] = (sb_count[k] != '0);
    end

    // R2: a pacing count above one forbids issue in the following cycle
    assert_pace_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && instr_stall > STALL_W'(1)) |=> !issue_fire);

    // R3: a busy waited counter blocks issue
    assert_wait_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && ((instr_wait_mask & nonzero) != '0)) |-> (!issue_fire && blocked));

    // R3: issue and blocked are exclusive
    assert_issue_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_fire && blocked));

    // R9: yield hint only with an issuing instruction that carries the flag
    assert_yield_tied_R9: assert property (@(posedge clk) disable iff (!rst_n)
        yield_hint |-> (issue_fire && instr_yield));

    // R8: error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_err |=> cmpl_err);

    // R8: out-of-range completion raises the flag
    assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_sb >= SEL_W'(NUM_SB)) |=> cmpl_err);

    for (genvar k = 0; k < NUM_SB; k++) begin : g_sb
        logic claim_k;
        logic done_k;
        assign claim_k = issue_fire && (instr_set_sb == SEL_W'(k));
        assign done_k  = cmpl_valid && (cmpl_sb == SEL_W'(k));

        // R4: a claim raises the counter by one
        assert_claim_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_k && !done_k && sb_count[k] != CMAX)
            |=> (sb_count[k] == CNT_W'($past(sb_count[k]) + 1'b1)));

        // R6: a completion lowers the counter by one
        assert_cmpl_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (done_k && !claim_k && sb_count[k] != '0)
            |=> (sb_count[k] == CNT_W'($past(sb_count[k]) - 1'b1)));

        // R7: claim and completion together hold the counter
        assert_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_k && done_k) |=> $stable(sb_count[k]));

        // R11: saturation at the maximum
        assert_saturate_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_k && !done_k && sb_count[k] == CMAX) |=> (sb_count[k] == CMAX));

        // R8: completion on an empty counter raises the flag and leaves it empty
        assert_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done_k && !claim_k && sb_count[k] == '0) |=> (cmpl_err && sb_count[k] == '0));
    end

endmodule

bind warp_issue_gate warp_issue_gate_chk #(
    .NUM_SB  (NUM_SB),
    .CNT_W   (CNT_W),
    .STALL_W (STALL_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .instr_valid     (instr_valid),
    .instr_stall     (instr_stall),
    .instr_yield     (instr_yield),
    .instr_set_sb    (instr_set_sb),
    .instr_wait_mask (instr_wait_mask),
    .cmpl_valid      (cmpl_valid),
    .cmpl_sb         (cmpl_sb),
    .issue_fire      (issue_fire),
    .blocked         (blocked),
    .yield_hint      (yield_hint),
    .cmpl_err        (cmpl_err),
    .sb_count        (sb_count)
);

// File: tb/warp_issue_gate_tb.sv
`timescale 1ns/1ps
module warp_issue_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic       instr_ready;
    logic [3:0] instr_stall = 4'd1;
    logic       instr_yield = 1'b0;
    logic [2:0] instr_set_sb = 3'd7;
    logic [5:0] instr_wait_mask = '0;
    logic       cmpl_valid = 1'b0;
    logic [2:0] cmpl_sb = '0;
    logic       issue_fire;
    logic       blocked;
    logic       yield_hint;
    logic       cmpl_err;

    always #2.5 clk = ~clk;

    warp_issue_gate u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .instr_valid     (instr_valid),
        .instr_ready     (instr_ready),
        .instr_stall     (instr_stall),
        .instr_yield     (instr_yield),
        .instr_set_sb    (instr_set_sb),
        .instr_wait_mask (instr_wait_mask),
        .cmpl_valid      (cmpl_valid),
        .cmpl_sb         (cmpl_sb),
        .issue_fire      (issue_fire),
        .blocked         (blocked),
        .yield_hint      (yield_hint),
        .cmpl_err        (cmpl_err)
    );

    typedef struct {
        int    cyc;
        logic  iss;
        logic  blk;
        logic  yld;
        logic  err;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp1(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Monitor: pops expectations due this cycle and compares away from the edge
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp1(e.req, "issue_fire", issue_fire, e.iss);
            cmp1(e.req, "blocked", blocked, e.blk);
            cmp1(e.req, "yield_hint", yield_hint, e.yld);
            cmp1(e.req, "cmpl_err", cmpl_err, e.err);
        end
    end

    // Driver: applies one cycle of stimulus and queues its expected outputs
    task automatic step(input logic v, input int stall, input logic y, input int set_sb,
                        input int mask, input logic cv, input int cs,
                        input logic e_iss, input logic e_blk, input logic e_y,
                        input logic e_err, input string req);
        exp_t e;
        instr_valid     = v;
        instr_stall     = 4'(stall);
        instr_yield     = y;
        instr_set_sb    = 3'(set_sb);
        instr_wait_mask = 6'(mask);
        cmpl_valid      = cv;
        cmpl_sb         = 3'(cs);
        e.cyc = cyc; e.iss = e_iss; e.blk = e_blk; e.yld = e_y; e.err = e_err; e.req = req;
        exp_q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        instr_valid = 1'b0; cmpl_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: first instruction issues at once; yield flag passed on issue (R9)
        step(1, 3, 1, 7, 0, 0, 0, 1, 0, 1, 0, "R1 R9");
        // R2: pacing of 3 holds two cycles; blocked yield gives no hint (R9)
        step(1, 1, 1, 7, 0, 0, 0, 0, 1, 0, 0, "R2 R9");
        step(1, 1, 0, 7, 0, 0, 0, 0, 1, 0, 0, "R2");
        step(1, 1, 0, 7, 0, 0, 0, 1, 0, 0, 0, "R2");
        step(1, 1, 0, 7, 0, 0, 0, 1, 0, 0, 0, "R2 back-to-back");
        step(1, 0, 0, 7, 0, 0, 0, 1, 0, 0, 0, "R2 stall zero");
        step(1, 1, 0, 7, 0, 0, 0, 1, 0, 0, 0, "R2 after stall zero");
        // R4/R3/R6: claim counter 2, consumer waits on bit 2
        step(1, 1, 0, 2, 0, 0, 0, 1, 0, 0, 0, "R4");
        step(1, 1, 0, 7, 6'b000100, 0, 0, 0, 1, 0, 0, "R3");
        step(1, 1, 0, 7, 6'b000100, 1, 2, 0, 1, 0, 0, "R6 same-cycle completion");
        step(1, 1, 0, 7, 6'b000100, 0, 0, 1, 0, 0, 0, "R6 release");
        // R5: two producers share counter 4
        step(1, 1, 0, 4, 0, 0, 0, 1, 0, 0, 0, "R5");
        step(1, 1, 0, 4, 0, 0, 0, 1, 0, 0, 0, "R5");
        step(1, 1, 0, 7, 6'b010000, 1, 4, 0, 1, 0, 0, "R5");
        step(1, 1, 0, 7, 6'b010000, 0, 0, 0, 1, 0, 0, "R5 R10 busy counter");
        step(1, 1, 0, 7, 6'b010000, 1, 4, 0, 1, 0, 0, "R5");
        step(1, 4, 0, 7, 6'b010000, 0, 0, 1, 0, 0, 0, "R5 released");
        // R10: countdown running with all counters clear
        step(1, 1, 0, 7, 0, 0, 0, 0, 1, 0, 0, "R10");
        step(1, 1, 0, 7, 0, 0, 0, 0, 1, 0, 0, "R10");
        step(1, 1, 0, 7, 0, 0, 0, 0, 1, 0, 0, "R10");
        step(1, 1, 0, 7, 0, 0, 0, 1, 0, 0, 0, "R10");
        // R4: claim value 6 claims nothing; full mask still issues
        step(1, 1, 0, 6, 0, 0, 0, 1, 0, 0, 0, "R4");
        step(1, 1, 0, 7, 6'b111111, 0, 0, 1, 0, 0, 0, "R4 none claimed");
        // R7: claim and completion on counter 1 together
        step(1, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R7");
        step(1, 1, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R7");
        step(1, 1, 0, 7, 6'b000010, 0, 0, 0, 1, 0, 0, "R7 count held");
        step(1, 1, 0, 7, 6'b000010, 1, 1, 0, 1, 0, 0, "R7");
        step(1, 1, 0, 7, 6'b000010, 0, 0, 1, 0, 0, 0, "R7");
        // R8: completion on empty counter 3
        step(0, 1, 0, 7, 0, 1, 3, 0, 0, 0, 0, "R8");
        step(0, 1, 0, 7, 0, 0, 0, 0, 0, 0, 1, "R8 flag set");
        step(1, 1, 0, 7, 6'b001000, 0, 0, 1, 0, 0, 1, "R8 counter unchanged");
        step(0, 1, 0, 7, 0, 0, 0, 0, 0, 0, 1, "R8 sticky");

        do_reset();
        step(0, 1, 0, 7, 0, 0, 0, 0, 0, 0, 0, "R1 R8 reset clears flag");
        step(0, 1, 0, 7, 0, 1, 7, 0, 0, 0, 0, "R8 index 7");
        step(0, 1, 0, 7, 0, 0, 0, 0, 0, 0, 1, "R8 index 7 flagged");

        do_reset();
        // R11: eight claims on counter 0 saturate at 7
        for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R11 claim");
        for (int i = 0; i < 6; i++) step(0, 1, 0, 7, 0, 1, 0, 0, 0, 0, 0, "R11 drain");
        step(1, 1, 0, 7, 6'b000001, 1, 0, 0, 1, 0, 0, "R11 one left");
        step(1, 1, 0, 7, 6'b000001, 0, 0, 1, 0, 0, 0, "R11 empty after 7");
        step(0, 1, 0, 7, 0, 1, 0, 0, 0, 0, 0, "R11 extra completion");
        step(0, 1, 0, 7, 0, 0, 0, 0, 0, 0, 1, "R11 R8 extra flagged");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL monitor queue not drained actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule